// File: doc/BRIEF.md
# Packet Receive FIFO with Commit and Rollback

This block buffers incoming OUT packets between a device-side write port and a bus-side read port, each running on its own clock. Words go into a data store as they arrive, but they stay speculative until an end-of-packet status comes in. A good status commits the packet and pushes a 32-bit descriptor into a small register FIFO. The descriptor carries the endpoint number, a flag and the byte count. A bad status rewinds the write pointer to the start of the packet, so the words are erased as though they had never arrived.

The reader sees the descriptor before it touches any data, so it knows the byte count in advance. It then pops the packet's words one at a time and confirms the packet with a single pulse. Pointer information crosses the clock boundary only at packet commits and packet confirms. Data space is handed back to the writer only after the reader has confirmed the packet. Any write attempt from the bus side is refused with an error pulse.

Top module: `pkt_rx_fifo`

## Requirements
- R1: After reset, `r_desc_valid`, `w_full`, `w_commit`, `w_drop` and `r_bus_err` are all low.
- R2: Each stored entry is 37 bits: 32 data bits, 4 byte-valid bits and an end-of-packet bit taken from `w_last`. The reader gets back `r_data`, `r_be` and `r_eop` exactly as written, in write order. `r_rd` advances to the next word.
- R3: When `w_end` is high with `w_ok` high, the packet commits, provided it neither overflowed nor hit a full descriptor FIFO. `w_commit` then pulses one `wclk` cycle later. A descriptor is published with the byte count (the sum of the set byte-valid bits) in bits [15:0], the endpoint in bits [19:16] and the flag in bit 24. All other bits are zero.
- R4: When `w_end` is high with `w_ok` low, `w_drop` pulses one `wclk` cycle later and no descriptor appears. The packet's space is reused, so the next committed packet reads back its own first word.
- R5: A word offered while the data area is full is not stored, and it marks the packet. At `w_end`, a marked packet is dropped even when `w_ok` is high. A packet that exactly fills the area still commits.
- R6: Data space is counted against the last confirmed read position. `w_full` and the overflow of R5 ignore words the reader has read but not yet confirmed.
- R7: With 2^DESC_AW descriptors outstanding, a further packet is dropped (`w_drop`) even when `w_ok` is high.
- R8: Descriptors are presented in commit order. `r_desc` is held stable until `r_done`, which pops it. `r_desc_valid` falls when no descriptor remains.
- R9: `r_bus_wr` yields an `r_bus_err` pulse on the next `rclk` cycle, and `r_bus_err` is never high otherwise.
- R10: `r_rd` and `r_done` have no effect while `r_desc_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write-side clock |
| wrst_n | input | 1 | Write-side asynchronous reset, active low |
| w_valid | input | 1 | Offer one word |
| w_data | input | 32 | Word data |
| w_be | input | 4 | Byte-valid bits of the word |
| w_last | input | 1 | Word is the last of the packet |
| w_end | input | 1 | End-of-packet status strobe |
| w_ok | input | 1 | Status with `w_end`: packet received without error |
| w_ep | input | 4 | Endpoint number, sampled with `w_end` |
| w_flag | input | 1 | Packet flag, sampled with `w_end` |
| w_full | output | 1 | Data area full against the confirmed read position |
| w_commit | output | 1 | Pulse: packet committed |
| w_drop | output | 1 | Pulse: packet discarded and rewound |
| rclk | input | 1 | Read-side clock |
| rrst_n | input | 1 | Read-side asynchronous reset, active low |
| r_desc_valid | output | 1 | A committed packet is waiting |
| r_desc | output | 32 | Descriptor of the oldest waiting packet |
| r_rd | input | 1 | Advance to the next word |
| r_data | output | 32 | Current word data |
| r_be | output | 4 | Current word byte-valid bits |
| r_eop | output | 1 | Current word is the last of its packet |
| r_done | input | 1 | Confirm the current packet as read |
| r_bus_wr | input | 1 | Bus-side write attempt |
| r_bus_err | output | 1 | Error response to a write attempt |

## Verification
The bench builds the block with a 16-word data area (ADDR_W=4) and four descriptor slots (DESC_AW=2). With these sizes a few short packets are enough to reach the exact-fill boundary, the overflow rewind and a full descriptor FIFO. A 10-word packet left unconfirmed leaves too little room for a second one, which shows that space comes back only on confirm. The two clocks run at unrelated periods, so both the walked pointer crossings and the descriptor crossing are exercised.

// File: rtl/pkt_rx_pkg.sv
`timescale 1ns/1ps
package pkt_rx_pkg;
    localparam int DATA_W      = 32;
    localparam int BE_W        = DATA_W / 8;
    localparam int EP_W        = 4;
    localparam int DESC_W      = 32;
    localparam int CNT_FIELD_W = 16;
    localparam int EP_LSB      = 16;
    localparam int FLAG_BIT    = 24;

    // 37-bit storage entry
    typedef struct packed {
        logic              eop;
        logic [BE_W-1:0]   be;
        logic [DATA_W-1:0] data;
    } word_t;

    function automatic logic [DESC_W-1:0] pack_desc(
        input logic [EP_W-1:0]        ep,
        input logic                   flag,
        input logic [CNT_FIELD_W-1:0] cnt
    );
        logic [DESC_W-1:0] d;
        d = '0;
        d[CNT_FIELD_W-1:0]  = cnt;
        d[EP_LSB +: EP_W]   = ep;
        d[FLAG_BIT]         = flag;
        return d;
    endfunction
endpackage

// File: rtl/pkt_ptr_cross.sv
`timescale 1ns/1ps
// Carries a pointer into another clock domain. The source-side follower
// walks one step per cycle toward the target, so the Gray value never
// changes by more than one bit between samples.
module pkt_ptr_cross #(
    parameter int W = 5
) (
    input  logic         src_clk,
    input  logic         src_rst_n,
    input  logic [W-1:0] src_target,
    input  logic         dst_clk,
    input  logic         dst_rst_n,
    output logic [W-1:0] dst_bin
);
    typedef struct packed {
        logic [W-1:0] follow;
        logic [W-1:0] gray;
    } src_t;

    typedef struct packed {
        logic [W-1:0] meta;
        logic [W-1:0] sync;
    } dst_t;

    src_t src_d, src_q;
    dst_t dst_d, dst_q;

    always_comb begin
        src_d = src_q;
        if (src_q.follow != src_target) begin
            src_d.follow = src_q.follow + W'(1);
        end
        src_d.gray = src_d.follow ^ (src_d.follow >> 1);
    end

    always_ff @(posedge src_clk or negedge src_rst_n) begin
        if (!src_rst_n) src_q <= '0;
        else            src_q <= src_d;
    end

    always_comb begin
        dst_d      = dst_q;
        dst_d.meta = src_q.gray;
        dst_d.sync = dst_q.meta;
    end

    always_ff @(posedge dst_clk or negedge dst_rst_n) begin
        if (!dst_rst_n) dst_q <= '0;
        else            dst_q <= dst_d;
    end

    always_comb begin
        logic [W-1:0] b;
        b[W-1] = dst_q.sync[W-1];
        for (int i = W - 2; i >= 0; i--) begin
            b[i] = b[i+1] ^ dst_q.sync[i];
        end
        dst_bin = b;
    end
endmodule

// File: rtl/pkt_wr_ctl.sv
`timescale 1ns/1ps
module pkt_wr_ctl
    import pkt_rx_pkg::*;
#(
    parameter int ADDR_W  = 9,
    parameter int DESC_AW = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                w_valid,
    input  logic [DATA_W-1:0]   w_data,
    input  logic [BE_W-1:0]     w_be,
    input  logic                w_last,
    input  logic                w_end,
    input  logic                w_ok,
    input  logic [EP_W-1:0]     w_ep,
    input  logic                w_flag,
    input  logic [ADDR_W:0]     rd_cmt_sync,
    input  logic [DESC_AW:0]    drd_sync,
    output logic                mem_we,
    output logic [ADDR_W-1:0]   mem_addr,
    output word_t               mem_word,
    output logic                desc_we,
    output logic [DESC_AW-1:0]  desc_addr,
    output logic [DESC_W-1:0]   desc_word,
    output logic [DESC_AW:0]    dwr_ptr,
    output logic                w_full,
    output logic                w_commit,
    output logic                w_drop
);
    localparam int DEPTH  = 1 << ADDR_W;
    localparam int PW     = ADDR_W + 1;
    localparam int DDEPTH = 1 << DESC_AW;
    localparam int DPW    = DESC_AW + 1;
    localparam int CNT_W  = ADDR_W + $clog2(BE_W) + 1;

    typedef struct packed {
        logic [PW-1:0]    wr;
        logic [PW-1:0]    start;
        logic [CNT_W-1:0] cnt;
        logic             ovf;
        logic [DPW-1:0]   dwr;
        logic             commit;
        logic             drop;
    } wr_state_t;

    wr_state_t s_d, s_q;

    logic [PW-1:0]    used;
    logic             full;
    logic             accept;
    logic [PW-1:0]    ptr_n;
    logic [CNT_W-1:0] cnt_n;
    logic             ovf_n;
    logic             dfull;
    logic             take;

    always_comb begin
        used   = s_q.wr - rd_cmt_sync;
        full   = (used == PW'(DEPTH));
        accept = w_valid && !full;
        ptr_n  = s_q.wr + PW'(accept);
        cnt_n  = s_q.cnt + (accept ? CNT_W'($countones(w_be)) : '0);
        ovf_n  = s_q.ovf | (w_valid & full);
        dfull  = ((s_q.dwr - drd_sync) == DPW'(DDEPTH));
        take   = w_end && w_ok && !ovf_n && !dfull;

        s_d        = s_q;
        s_d.commit = 1'b0;
        s_d.drop   = 1'b0;
        if (w_end) begin
            s_d.cnt = '0;
            s_d.ovf = 1'b0;
            if (take) begin
                s_d.wr     = ptr_n;
                s_d.start  = ptr_n;
                s_d.dwr    = s_q.dwr + DPW'(1);
                s_d.commit = 1'b1;
            end else begin
                s_d.wr   = s_q.start;
                s_d.drop = 1'b1;
            end
        end else begin
            s_d.wr  = ptr_n;
            s_d.cnt = cnt_n;
            s_d.ovf = ovf_n;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign mem_we    = accept;
    assign mem_addr  = s_q.wr[ADDR_W-1:0];
    assign mem_word  = '{eop: w_last, be: w_be, data: w_data};
    assign desc_we   = take;
    assign desc_addr = s_q.dwr[DESC_AW-1:0];
    assign desc_word = pack_desc(w_ep, w_flag, CNT_FIELD_W'(cnt_n));
    assign dwr_ptr   = s_q.dwr;
    assign w_full    = full;
    assign w_commit  = s_q.commit;
    assign w_drop    = s_q.drop;
endmodule

// File: rtl/pkt_rd_ctl.sv
`timescale 1ns/1ps
module pkt_rd_ctl #(
    parameter int ADDR_W  = 9,
    parameter int DESC_AW = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               r_rd,
    input  logic               r_done,
    input  logic               r_bus_wr,
    input  logic [DESC_AW:0]   dwr_sync,
    output logic [ADDR_W-1:0]  rd_addr,
    output logic [ADDR_W:0]    rd_cmt,
    output logic [DESC_AW:0]   drd_ptr,
    output logic               desc_valid,
    output logic               bus_err
);
    localparam int PW  = ADDR_W + 1;
    localparam int DPW = DESC_AW + 1;

    typedef struct packed {
        logic [PW-1:0]  rd;
        logic [PW-1:0]  cmt;
        logic [DPW-1:0] drd;
        logic           err;
    } rd_state_t;

    rd_state_t s_d, s_q;
    logic      valid;

    always_comb begin
        valid   = (dwr_sync != s_q.drd);
        s_d     = s_q;
        s_d.err = r_bus_wr;
        if (valid && r_rd) begin
            s_d.rd = s_q.rd + PW'(1);
        end
        if (valid && r_done) begin
            s_d.cmt = s_d.rd;
            s_d.drd = s_q.drd + DPW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign rd_addr    = s_q.rd[ADDR_W-1:0];
    assign rd_cmt     = s_q.cmt;
    assign drd_ptr    = s_q.drd;
    assign desc_valid = valid;
    assign bus_err    = s_q.err;
endmodule

// File: rtl/pkt_rx_fifo.sv
`timescale 1ns/1ps
module pkt_rx_fifo
    import pkt_rx_pkg::*;
#(
    parameter int ADDR_W  = 9,
    parameter int DESC_AW = 2
) (
    input  logic              wclk,
    input  logic              wrst_n,
    input  logic              w_valid,
    input  logic [DATA_W-1:0] w_data,
    input  logic [BE_W-1:0]   w_be,
    input  logic              w_last,
    input  logic              w_end,
    input  logic              w_ok,
    input  logic [EP_W-1:0]   w_ep,
    input  logic              w_flag,
    output logic              w_full,
    output logic              w_commit,
    output logic              w_drop,
    input  logic              rclk,
    input  logic              rrst_n,
    output logic              r_desc_valid,
    output logic [DESC_W-1:0] r_desc,
    input  logic              r_rd,
    output logic [DATA_W-1:0] r_data,
    output logic [BE_W-1:0]   r_be,
    output logic              r_eop,
    input  logic              r_done,
    input  logic              r_bus_wr,
    output logic              r_bus_err
);
    localparam int DEPTH  = 1 << ADDR_W;
    localparam int DDEPTH = 1 << DESC_AW;

    word_t             data_mem [DEPTH];
    logic [DESC_W-1:0] desc_mem [DDEPTH];

    logic               mem_we;
    logic [ADDR_W-1:0]  mem_addr;
    word_t              mem_word;
    logic               desc_we;
    logic [DESC_AW-1:0] desc_addr;
    logic [DESC_W-1:0]  desc_word;
    logic [DESC_AW:0]   dwr_ptr, dwr_sync;
    logic [DESC_AW:0]   drd_ptr, drd_sync;
    logic [ADDR_W:0]    rd_cmt, rd_cmt_sync;
    logic [ADDR_W-1:0]  rd_addr;
    logic               desc_valid;
    word_t              rd_word;

    pkt_wr_ctl #(.ADDR_W(ADDR_W), .DESC_AW(DESC_AW)) u_wr (
        .clk(wclk), .rst_n(wrst_n),
        .w_valid(w_valid), .w_data(w_data), .w_be(w_be), .w_last(w_last),
        .w_end(w_end), .w_ok(w_ok), .w_ep(w_ep), .w_flag(w_flag),
        .rd_cmt_sync(rd_cmt_sync), .drd_sync(drd_sync),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_word(mem_word),
        .desc_we(desc_we), .desc_addr(desc_addr), .desc_word(desc_word),
        .dwr_ptr(dwr_ptr), .w_full(w_full), .w_commit(w_commit), .w_drop(w_drop)
    );

    pkt_rd_ctl #(.ADDR_W(ADDR_W), .DESC_AW(DESC_AW)) u_rd (
        .clk(rclk), .rst_n(rrst_n),
        .r_rd(r_rd), .r_done(r_done), .r_bus_wr(r_bus_wr),
        .dwr_sync(dwr_sync),
        .rd_addr(rd_addr), .rd_cmt(rd_cmt), .drd_ptr(drd_ptr),
        .desc_valid(desc_valid), .bus_err(r_bus_err)
    );

    pkt_ptr_cross #(.W(ADDR_W + 1)) u_cmt_x (
        .src_clk(rclk), .src_rst_n(rrst_n), .src_target(rd_cmt),
        .dst_clk(wclk), .dst_rst_n(wrst_n), .dst_bin(rd_cmt_sync)
    );

    pkt_ptr_cross #(.W(DESC_AW + 1)) u_drd_x (
        .src_clk(rclk), .src_rst_n(rrst_n), .src_target(drd_ptr),
        .dst_clk(wclk), .dst_rst_n(wrst_n), .dst_bin(drd_sync)
    );

    pkt_ptr_cross #(.W(DESC_AW + 1)) u_dwr_x (
        .src_clk(wclk), .src_rst_n(wrst_n), .src_target(dwr_ptr),
        .dst_clk(rclk), .dst_rst_n(rrst_n), .dst_bin(dwr_sync)
    );

    always_ff @(posedge wclk) begin
        if (mem_we) data_mem[mem_addr] <= mem_word;
    end

    always_ff @(posedge wclk) begin
        if (desc_we) desc_mem[desc_addr] <= desc_word;
    end

    assign rd_word      = data_mem[rd_addr];
    assign r_data       = rd_word.data;
    assign r_be         = rd_word.be;
    assign r_eop        = rd_word.eop;
    assign r_desc_valid = desc_valid;
    assign r_desc       = desc_valid ? desc_mem[drd_ptr[DESC_AW-1:0]] : '0;
endmodule

// File: rtl/pkt_rx_fifo_checker.sv
`timescale 1ns/1ps
module pkt_rx_fifo_checker (
    input logic        wclk,
    input logic        wrst_n,
    input logic        w_end,
    input logic        w_ok,
    input logic        w_commit,
    input logic        w_drop,
    input logic        rclk,
    input logic        rrst_n,
    input logic        r_desc_valid,
    input logic [31:0] r_desc,
    input logic        r_done,
    input logic        r_bus_wr,
    input logic        r_bus_err
);
    a_r3_commit_needs_ok: assert property (@(posedge wclk) disable iff (!wrst_n)
        w_commit |-> $past(w_end && w_ok));

    a_r4_drop_needs_end: assert property (@(posedge wclk) disable iff (!wrst_n)
        w_drop |-> $past(w_end));

    a_r4_commit_drop_excl: assert property (@(posedge wclk) disable iff (!wrst_n)
        !(w_commit && w_drop));

    a_r8_desc_held: assert property (@(posedge rclk) disable iff (!rrst_n)
        (r_desc_valid && !r_done) |=> (r_desc_valid && $stable(r_desc)));

    a_r9_err_follows_wr: assert property (@(posedge rclk) disable iff (!rrst_n)
        r_bus_wr |=> r_bus_err);

    a_r9_err_only_on_wr: assert property (@(posedge rclk) disable iff (!rrst_n)
        r_bus_err |-> $past(r_bus_wr));
endmodule

bind pkt_rx_fifo pkt_rx_fifo_checker u_checker (
    .wclk(wclk), .wrst_n(wrst_n), .w_end(w_end), .w_ok(w_ok),
    .w_commit(w_commit), .w_drop(w_drop),
    .rclk(rclk), .rrst_n(rrst_n), .r_desc_valid(r_desc_valid),
    .r_desc(r_desc), .r_done(r_done),
    .r_bus_wr(r_bus_wr), .r_bus_err(r_bus_err)
);

// File: tb/pkt_rx_fifo_bench.sv
`timescale 1ns/1ps
module pkt_rx_fifo_bench;
    localparam int AW  = 4;
    localparam int DAW = 2;

    logic wclk = 1'b0;
    logic rclk = 1'b0;
    always #2   wclk = ~wclk;
    always #3.5 rclk = ~rclk;

    logic        wrst_n, rrst_n;
    logic        w_valid, w_last, w_end, w_ok, w_flag;
    logic [31:0] w_data;
    logic [3:0]  w_be, w_ep;
    logic        w_full, w_commit, w_drop;
    logic        r_desc_valid, r_rd, r_eop, r_done, r_bus_wr, r_bus_err;
    logic [31:0] r_desc, r_data;
    logic [3:0]  r_be;

    int n_chk = 0;
    int n_err = 0;
    bit done  = 1'b0;

    pkt_rx_fifo #(.ADDR_W(AW), .DESC_AW(DAW)) u_pkt_rx_fifo (
        .wclk(wclk), .wrst_n(wrst_n), .w_valid(w_valid), .w_data(w_data),
        .w_be(w_be), .w_last(w_last), .w_end(w_end), .w_ok(w_ok),
        .w_ep(w_ep), .w_flag(w_flag), .w_full(w_full), .w_commit(w_commit),
        .w_drop(w_drop), .rclk(rclk), .rrst_n(rrst_n),
        .r_desc_valid(r_desc_valid), .r_desc(r_desc), .r_rd(r_rd),
        .r_data(r_data), .r_be(r_be), .r_eop(r_eop), .r_done(r_done),
        .r_bus_wr(r_bus_wr), .r_bus_err(r_bus_err)
    );

    task automatic chk(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic send_pkt(input int n, input logic [31:0] base,
                            input logic [3:0] lastbe, input logic [3:0] ep,
                            input logic flag, input logic ok,
                            output logic cmt, output logic drp);
        @(negedge wclk);
        for (int i = 0; i < n; i++) begin
            w_valid = 1'b1;
            w_data  = base + 32'(i);
            w_be    = (i == n - 1) ? lastbe : 4'hF;
            w_last  = (i == n - 1);
            w_end   = (i == n - 1);
            w_ok    = ok;
            w_ep    = ep;
            w_flag  = flag;
            @(negedge wclk);
        end
        w_valid = 1'b0; w_last = 1'b0; w_end = 1'b0; w_ok = 1'b0;
        cmt = w_commit;
        drp = w_drop;
    endtask

    task automatic wait_desc(output logic got);
        got = 1'b0;
        for (int i = 0; i < 40 && !got; i++) begin
            @(negedge rclk);
            got = r_desc_valid;
        end
    endtask

    task automatic settle();
        repeat (80) @(negedge wclk);
    endtask

    // Reads one packet, checking its descriptor (R3) and words (R2), then confirms it.
    task automatic read_pkt(input string req, input int n, input logic [31:0] base,
                            input logic [3:0] lastbe, input logic [3:0] ep,
                            input logic flag);
        logic got;
        wait_desc(got);
        chk(req, "descriptor present", 64'(got), 64'd1);
        chk(req, "byte count", 64'(r_desc[15:0]), 64'((n - 1) * 4 + $countones(lastbe)));
        chk(req, "endpoint", 64'(r_desc[19:16]), 64'(ep));
        chk(req, "flag", 64'(r_desc[24]), 64'(flag));
        chk(req, "reserved zero", 64'({r_desc[31:25], r_desc[23:20]}), 64'd0);
        for (int i = 0; i < n; i++) begin
            chk(req, "word", 64'({r_eop, r_be, r_data}),
                64'({(i == n - 1), ((i == n - 1) ? lastbe : 4'hF), base + 32'(i)}));
            r_rd = 1'b1;
            @(negedge rclk);
            r_rd = 1'b0;
        end
        r_done = 1'b1;
        @(negedge rclk);
        r_done = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1", "r_desc_valid", 64'(r_desc_valid), 64'd0);
        chk("R1", "w_full", 64'(w_full), 64'd0);
        chk("R1", "w_commit", 64'(w_commit), 64'd0);
        chk("R1", "w_drop", 64'(w_drop), 64'd0);
        chk("R1", "r_bus_err", 64'(r_bus_err), 64'd0);
    endtask

    task automatic t_basic();
        logic c, d;
        send_pkt(3, 32'h100, 4'b0011, 4'd5, 1'b1, 1'b1, c, d);
        chk("R3", "commit pulse", 64'({c, d}), 64'b10);
        read_pkt("R2", 3, 32'h100, 4'b0011, 4'd5, 1'b1);
        chk("R8", "valid falls after last pop", 64'(r_desc_valid), 64'd0);
    endtask

    task automatic t_error();
        logic c, d;
        send_pkt(4, 32'h200, 4'hF, 4'd2, 1'b0, 1'b0, c, d);
        chk("R4", "drop pulse", 64'({c, d}), 64'b01);
        repeat (40) @(negedge rclk);
        chk("R4", "no descriptor", 64'(r_desc_valid), 64'd0);
        send_pkt(2, 32'h300, 4'h7, 4'd3, 1'b0, 1'b1, c, d);
        chk("R4", "next packet commits", 64'({c, d}), 64'b10);
        read_pkt("R4", 2, 32'h300, 4'h7, 4'd3, 1'b0);
    endtask

    task automatic t_exact_fill();
        logic c, d;
        settle();
        send_pkt(16, 32'h400, 4'hF, 4'd9, 1'b0, 1'b1, c, d);
        chk("R5", "exact fill commits", 64'({c, d}), 64'b10);
        chk("R6", "full while unconfirmed", 64'(w_full), 64'd1);
        read_pkt("R5", 16, 32'h400, 4'hF, 4'd9, 1'b0);
        settle();
        chk("R6", "full clears after confirm", 64'(w_full), 64'd0);
    endtask

    task automatic t_hold_space();
        logic c, d;
        send_pkt(10, 32'h500, 4'hF, 4'd1, 1'b0, 1'b1, c, d);
        chk("R6", "first packet commits", 64'({c, d}), 64'b10);
        send_pkt(10, 32'h520, 4'hF, 4'd1, 1'b0, 1'b1, c, d);
        chk("R6", "no room before confirm", 64'({c, d}), 64'b01);
        read_pkt("R6", 10, 32'h500, 4'hF, 4'd1, 1'b0);
        settle();
        send_pkt(10, 32'h540, 4'hF, 4'd1, 1'b1, 1'b1, c, d);
        chk("R6", "room after confirm", 64'({c, d}), 64'b10);
        read_pkt("R6", 10, 32'h540, 4'hF, 4'd1, 1'b1);
    endtask

    task automatic t_overflow();
        logic c, d;
        settle();
        send_pkt(20, 32'h600, 4'hF, 4'd4, 1'b0, 1'b1, c, d);
        chk("R5", "oversize packet dropped", 64'({c, d}), 64'b01);
        repeat (40) @(negedge rclk);
        chk("R5", "no descriptor", 64'(r_desc_valid), 64'd0);
    endtask

    task automatic t_desc_full();
        logic c, d;
        settle();
        for (int k = 0; k < 4; k++) begin
            send_pkt(1, 32'h800 + 32'(k), 4'h1, 4'(k + 1), 1'b0, 1'b1, c, d);
            chk("R7", "commit while slots free", 64'({c, d}), 64'b10);
        end
        send_pkt(1, 32'h8FF, 4'h1, 4'd15, 1'b0, 1'b1, c, d);
        chk("R7", "drop when slots full", 64'({c, d}), 64'b01);
        for (int k = 0; k < 4; k++) begin
            read_pkt("R8", 1, 32'h800 + 32'(k), 4'h1, 4'(k + 1), 1'b0);
        end
        chk("R8", "all popped", 64'(r_desc_valid), 64'd0);
    endtask

    task automatic t_bus_write();
        @(negedge rclk);
        r_bus_wr = 1'b1;
        @(negedge rclk);
        r_bus_wr = 1'b0;
        chk("R9", "error pulse", 64'(r_bus_err), 64'd1);
        @(negedge rclk);
        chk("R9", "error ends", 64'(r_bus_err), 64'd0);
    endtask

    task automatic t_ignored();
        logic c, d;
        settle();
        @(negedge rclk);
        r_rd = 1'b1;
        repeat (3) @(negedge rclk);
        r_rd = 1'b0;
        r_done = 1'b1;
        @(negedge rclk);
        r_done = 1'b0;
        chk("R10", "still empty", 64'(r_desc_valid), 64'd0);
        send_pkt(1, 32'h700, 4'h1, 4'd6, 1'b1, 1'b1, c, d);
        read_pkt("R10", 1, 32'h700, 4'h1, 4'd6, 1'b1);
    endtask

    initial begin
        wrst_n = 1'b0; rrst_n = 1'b0;
        w_valid = 1'b0; w_data = '0; w_be = '0; w_last = 1'b0;
        w_end = 1'b0; w_ok = 1'b0; w_ep = '0; w_flag = 1'b0;
        r_rd = 1'b0; r_done = 1'b0; r_bus_wr = 1'b0;
        #30;
        @(negedge wclk);
        wrst_n = 1'b1; rrst_n = 1'b1;
        repeat (4) @(negedge wclk);
        t_reset();
        t_basic();
        t_error();
        t_exact_fill();
        t_hold_space();
        t_overflow();
        t_desc_full();
        t_bus_write();
        t_ignored();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge wclk);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end
endmodule